// File: doc/BRIEF.md
# Cascadable Serial Configuration Memory

This block is the read side of a serial bitstream store that is programmed once. Its contents are fixed when the design is elaborated. An external clock reads the store one bit per rising edge. An internal address counter picks the bit, and that bit appears on a data output that can be turned off. The output is modelled as a value plus a drive-enable, so a shared line can be resolved outside the block.

The block has two control inputs. One is an active-low chip enable. The other is a combined reset/output-enable pin, and a parameter sets whether its reset level is high or low. After the last bit has been read, the counter stops and this device releases the data line. A chip-enable output then goes low, and it drives the chip enable of the next device. In this way several devices on one clock and one data line deliver a single long bitstream.

Top module: `cfg_serial_store`

## Requirements
- R1: While reset is inactive and chip enable is active, each rising clock edge advances the address by one. The bit at address k is bit k of `INIT_BITS`, so bit 0 comes first. The current bit is on `data_o` from reset release, before the first edge.
- R2: While reset is active, `data_oe` is low at once, and the address returns to 0 at the next rising edge. After release, bit 0 is presented again.
- R3: With `RST_ACTIVE_HIGH` = 1, a high level on `rst_oe` is reset and a low level enables the output. With `RST_ACTIVE_HIGH` = 0, the roles are swapped.
- R4: While `ce_n` is high, the address holds its value and `data_oe` is low. When `ce_n` returns low, reading resumes at the held address.
- R5: After `DEPTH` advancing edges, the device is past its terminal count. The address then stops advancing and `data_oe` stays low.
- R6: `ceo_n` is low exactly when chip enable is active, reset is inactive and the device is past its terminal count. After the terminal count, `ceo_n` follows `ce_n`.
- R7: When reset is applied to a spent device, `ceo_n` goes high at once and stays high after release, because reading starts again at bit 0.
- R8: In a chain, each device's `ceo_n` drives the next device's `ce_n`, and all devices share the clock and data line. Exactly one device drives at a time, and the line carries the concatenated contents with no gap or repeated bit.
- R9: `data_o` is 0 whenever `data_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Read clock; the address advances on its rising edge |
| rst_oe | input | 1 | Combined reset / output enable; the reset level is set by `RST_ACTIVE_HIGH` |
| ce_n | input | 1 | Chip enable, active low |
| data_o | output | 1 | Current bit value |
| data_oe | output | 1 | High when this device drives the data line |
| ceo_n | output | 1 | Chip-enable output for the next device, active low |

## Verification
The bench reads the full array and then keeps clocking past the end. A counter that does not stop would wrap, drive again, or raise `ceo_n`. It applies reset to a spent device and checks that the hand-off is withdrawn at once and that bit 0 returns. If the done state were never cleared, the next device would keep driving the line. It pauses chip enable in the middle of a read and checks that reading resumes at the next bit. A design that advanced while disabled would skip bits. A chain of three devices with an active-low reset must deliver 24 bits with exactly one driver on each cycle. A hand-off one cycle late or one cycle early shows up as a gap or as two drivers on the line.

// File: rtl/cfg_store_pkg.sv
package cfg_store_pkg;

    // Decoded control state seen by the datapath
    typedef struct packed {
        logic ce;   // chip enable active
        logic oe;   // output enable active (reset inactive)
    } enab_t;

    // Width of an address counter that can also hold the value DEPTH
    function automatic int unsigned ctr_width(input int unsigned depth);
        return $clog2(depth + 1);
    endfunction

    // True when a pin sits at its active level
    function automatic logic at_level(input logic pin, input bit active_high);
        return active_high ? pin : ~pin;
    endfunction

endpackage

// File: rtl/cfg_pin_decode.sv
module cfg_pin_decode
    import cfg_store_pkg::*;
#(
    parameter bit RST_ACTIVE_HIGH = 1'b1
) (
    input  logic  rst_oe,
    input  logic  ce_n,
    output enab_t en,
    output logic  rst_act
);
    generate
        if (RST_ACTIVE_HIGH) begin : g_rst_high
            assign rst_act = at_level(rst_oe, 1'b1);
        end else begin : g_rst_low
            assign rst_act = at_level(rst_oe, 1'b0);
        end
    endgenerate

    assign en.oe = ~rst_act;
    assign en.ce = ~ce_n;
endmodule

// File: rtl/cfg_addr_ctr.sv
module cfg_addr_ctr
    import cfg_store_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    localparam int unsigned AW = ctr_width(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_act,
    input  logic          ce_act,
    output logic [AW-1:0] addr,
    output logic          spent
);
    localparam logic [AW-1:0] END_ADDR = AW'(DEPTH);

    assign spent = (addr == END_ADDR);

    always_ff @(posedge clk) begin
        if (rst_act) begin
            addr <= '0;
        end else if (ce_act && !spent) begin
            addr <= addr + AW'(1);
        end
    end

    // R1
    advance_chk: assert property (@(posedge clk) disable iff (rst_act)
        (ce_act && !spent) |=> (addr == $past(addr) + AW'(1)));

    // R2
    reset_zero_chk: assert property (@(posedge clk)
        rst_act |=> (addr == '0));

    // R4
    freeze_chk: assert property (@(posedge clk) disable iff (rst_act)
        !ce_act |=> $stable(addr));

    // R5
    saturate_chk: assert property (@(posedge clk) disable iff (rst_act)
        spent |=> (spent && $stable(addr)));
endmodule

// File: rtl/cfg_bit_rom.sv
module cfg_bit_rom
    import cfg_store_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    parameter logic [DEPTH-1:0] INIT_BITS = '0,
    localparam int unsigned AW = ctr_width(DEPTH),
    localparam int unsigned IW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic [AW-1:0] addr,
    output logic          rd_bit
);
    logic [DEPTH-1:0] cells;

    generate
        for (genvar i = 0; i < DEPTH; i++) begin : g_cell
            assign cells[i] = INIT_BITS[i];
        end
    endgenerate

    logic in_range;
    assign in_range = (addr < AW'(DEPTH));
    assign rd_bit   = in_range ? cells[addr[IW-1:0]] : 1'b0;
endmodule

// File: rtl/cfg_out_ctl.sv
module cfg_out_ctl
    import cfg_store_pkg::*;
(
    input  enab_t en,
    input  logic  spent,
    input  logic  rd_bit,
    output logic  data_o,
    output logic  data_oe,
    output logic  ceo_n
);
    logic live;
    assign live    = en.ce && en.oe;
    assign data_oe = live && !spent;
    assign data_o  = data_oe ? rd_bit : 1'b0;
    assign ceo_n   = !(live && spent);
endmodule

// File: rtl/cfg_serial_store.sv
module cfg_serial_store
    import cfg_store_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    parameter logic [DEPTH-1:0] INIT_BITS = 64'hA5C3_0F96_1E2D_3C4B,
    parameter bit RST_ACTIVE_HIGH = 1'b1,
    localparam int unsigned AW = ctr_width(DEPTH)
) (
    input  logic clk,
    input  logic rst_oe,
    input  logic ce_n,
    output logic data_o,
    output logic data_oe,
    output logic ceo_n
);
    enab_t         en;
    logic          rst_act;
    logic [AW-1:0] addr;
    logic          spent;
    logic          rd_bit;

    cfg_pin_decode #(.RST_ACTIVE_HIGH(RST_ACTIVE_HIGH)) u_dec (
        .rst_oe (rst_oe),
        .ce_n   (ce_n),
        .en     (en),
        .rst_act(rst_act)
    );

    cfg_addr_ctr #(.DEPTH(DEPTH)) u_ctr (
        .clk    (clk),
        .rst_act(rst_act),
        .ce_act (en.ce),
        .addr   (addr),
        .spent  (spent)
    );

    cfg_bit_rom #(.DEPTH(DEPTH), .INIT_BITS(INIT_BITS)) u_rom (
        .addr  (addr),
        .rd_bit(rd_bit)
    );

    cfg_out_ctl u_out (
        .en     (en),
        .spent  (spent),
        .rd_bit (rd_bit),
        .data_o (data_o),
        .data_oe(data_oe),
        .ceo_n  (ceo_n)
    );

    // R6
    drive_handoff_chk: assert property (@(posedge clk) disable iff (rst_act)
        !(data_oe && !ceo_n));

    // R9
    quiet_line_chk: assert property (@(posedge clk) disable iff (rst_act)
        !data_oe |-> !data_o);
endmodule

// File: tb/cfg_serial_store_tb.sv
module cfg_serial_store_tb_top;
    localparam logic [63:0] EXP = 64'hA5C3_0F96_1E2D_3C4B;
    localparam logic [7:0]  C0 = 8'hB4, C1 = 8'h3C, C2 = 8'hE1;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    int errs = 0;
    int checks = 0;

    // main device, active-high reset
    logic rst_oe = 1'b1, ce_n = 1'b0;
    logic data_o, data_oe, ceo_n;

    cfg_serial_store dut_i (
        .clk(clk), .rst_oe(rst_oe), .ce_n(ce_n),
        .data_o(data_o), .data_oe(data_oe), .ceo_n(ceo_n)
    );

    // chain of three, active-low reset
    logic rstc = 1'b0, cec_n = 1'b0;
    logic [2:0] cd, coe, cceo;

    cfg_serial_store #(.DEPTH(8), .INIT_BITS(C0), .RST_ACTIVE_HIGH(1'b0)) ch0 (
        .clk(clk), .rst_oe(rstc), .ce_n(cec_n),
        .data_o(cd[0]), .data_oe(coe[0]), .ceo_n(cceo[0]));
    cfg_serial_store #(.DEPTH(8), .INIT_BITS(C1), .RST_ACTIVE_HIGH(1'b0)) ch1 (
        .clk(clk), .rst_oe(rstc), .ce_n(cceo[0]),
        .data_o(cd[1]), .data_oe(coe[1]), .ceo_n(cceo[1]));
    cfg_serial_store #(.DEPTH(8), .INIT_BITS(C2), .RST_ACTIVE_HIGH(1'b0)) ch2 (
        .clk(clk), .rst_oe(rstc), .ce_n(cceo[1]),
        .data_o(cd[2]), .data_oe(coe[2]), .ceo_n(cceo[2]));

    logic line;
    assign line = |(cd & coe);

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errs++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic t_reset();
        rst_oe = 1'b1; ce_n = 1'b0;
        @(negedge clk);
        chk("R3 reset-high disables drive", {31'd0, data_oe}, 0);
        chk("R9 data zero when undriven", {31'd0, data_o}, 0);
        chk("R2 ceo_n high in reset", {31'd0, ceo_n}, 1);
        @(negedge clk);
        rst_oe = 1'b0; #1;
    endtask

    task automatic t_full_read();
        t_reset();
        for (int k = 0; k < 64; k++) begin
            chk($sformatf("R1 drive bit %0d", k), {31'd0, data_oe}, 1);
            chk($sformatf("R1 value bit %0d", k), {31'd0, data_o}, {31'd0, EXP[k]});
            @(negedge clk); #1;
        end
        for (int k = 0; k < 3; k++) begin
            chk("R5 released after terminal count", {31'd0, data_oe}, 0);
            chk("R6 ceo_n low when spent", {31'd0, ceo_n}, 0);
            @(negedge clk); #1;
        end
        ce_n = 1'b1; #1;
        chk("R6 ceo_n follows ce_n high", {31'd0, ceo_n}, 1);
        @(negedge clk);
        ce_n = 1'b0; #1;
        chk("R6 ceo_n follows ce_n low", {31'd0, ceo_n}, 0);
        chk("R5 still released", {31'd0, data_oe}, 0);
    endtask

    task automatic t_reset_spent();
        // device is spent on entry
        rst_oe = 1'b1; #1;
        chk("R7 ceo_n high at reset", {31'd0, ceo_n}, 1);
        @(negedge clk);
        rst_oe = 1'b0; #1;
        chk("R7 ceo_n high after release", {31'd0, ceo_n}, 1);
        chk("R7 drives again", {31'd0, data_oe}, 1);
        chk("R7 restarts at bit 0", {31'd0, data_o}, {31'd0, EXP[0]});
    endtask

    task automatic t_freeze();
        t_reset();
        for (int k = 0; k < 10; k++) begin
            @(negedge clk); #1;
        end
        ce_n = 1'b1; #1;
        for (int k = 0; k < 5; k++) begin
            chk("R4 no drive while disabled", {31'd0, data_oe}, 0);
            chk("R9 data zero while disabled", {31'd0, data_o}, 0);
            chk("R4 ceo_n high while disabled", {31'd0, ceo_n}, 1);
            @(negedge clk); #1;
        end
        ce_n = 1'b0; #1;
        chk("R4 resumes at bit 10", {31'd0, data_o}, {31'd0, EXP[10]});
        @(negedge clk); #1;
        chk("R4 then bit 11", {31'd0, data_o}, {31'd0, EXP[11]});
    endtask

    task automatic t_mid_reset();
        t_reset();
        for (int k = 0; k < 5; k++) begin
            @(negedge clk); #1;
        end
        chk("R1 at bit 5", {31'd0, data_o}, {31'd0, EXP[5]});
        rst_oe = 1'b1; #1;
        chk("R2 drive off at once", {31'd0, data_oe}, 0);
        @(negedge clk);
        rst_oe = 1'b0; #1;
        chk("R2 bit 0 after reset", {31'd0, data_o}, {31'd0, EXP[0]});
        @(negedge clk); #1;
        chk("R2 bit 1 after reset", {31'd0, data_o}, {31'd0, EXP[1]});
    endtask

    task automatic t_chain();
        logic [23:0] stream;
        stream = {C2, C1, C0};
        rstc = 1'b0; cec_n = 1'b0;
        @(negedge clk); #1;
        chk("R3 active-low reset holds chain quiet", {29'd0, coe}, 0);
        @(negedge clk);
        rstc = 1'b1; #1;
        for (int k = 0; k < 24; k++) begin
            chk($sformatf("R8 one driver at bit %0d", k), $countones(coe), 1);
            chk($sformatf("R8 line bit %0d", k), {31'd0, line}, {31'd0, stream[k]});
            @(negedge clk); #1;
        end
        chk("R8 chain released at end", {29'd0, coe}, 0);
        chk("R8 last ceo_n low", {31'd0, cceo[2]}, 0);
    endtask

    initial begin
        fork
            begin
                t_full_read();
                t_reset_spent();
                t_freeze();
                t_mid_reset();
                t_chain();
            end
            begin
                repeat (20000) @(posedge clk);
                errs++; checks++;
                $display("FAIL watchdog: actual=expired expected=done");
            end
        join_any
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end
endmodule